// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This block holds the hardware debug state of a processor core: four address slots, a status word and a control word, all reached through a small indexed register port. Each cycle it can be told about a retiring instruction address, a data access (address, size and direction), a single-step event and a task switch. It compares the instruction address against the execute-type slots and the data access against the watch-type slots. It then updates the status word and emits a one-cycle debug-exception request.

The control word holds two enable bits, a two-bit kind and a two-bit length code for every slot. The kind and length fields sit on a two-bit stride, so the length code of slot i is the same pair of bits as the kind of slot i+1. Hit bits in the status word are rebuilt on every check and include slots that are disabled. The rebuilt value is kept only when an enabled slot hit or when a single step forces it. Delivery of the exception, privilege rules and I/O-port matching belong to the surrounding core.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every address slot reads 0, the status word reads 0xFFFF0FF0 and the control word reads 0x00000400. Those one-bits stay set at all times.
- R2: Register index 0..3 selects address slot 0..3, index 6 (alias 4) the status word and index 7 (alias 5) the control word. A write ORs in the fixed one-bits. Read data appears on the clock edge after the index is presented. A status write in the same cycle as a status update wins.
- R3: For slot i, control bits [2i+1:2i] are the enables, with bit 2i local and bit 2i+1 global, and the slot is enabled if either is set. Bits [17+2i:16+2i] hold the kind and bits [19+2i:18+2i] the length code. The length code decodes as 0→1 byte, 1→2, 2→8 and 3→4.
- R4: A slot of kind 0 (execute) matches when a valid instruction address equals its address exactly.
- R5: A slot of kind 1 or 3 matches a valid data access when the access bytes [addr, addr+size) overlap the slot range. The slot range starts at the slot address aligned down to its length and spans that length. The access size code is 0→1, 1→2, 2→4 and 3→8 bytes.
- R6: Kind 1 matches writes only. Kind 3 matches reads and writes. Kind 2 never matches.
- R7: On each check, status bits [3:0] are rebuilt with bit i set for every matching slot, enabled or not. The rebuilt word is stored only if an enabled slot matched or a single step occurred; otherwise status is unchanged.
- R8: The debug-exception output is high for one cycle, on the edge after the event, exactly when an enabled slot matched or a single step occurred.
- R9: A single step forces the status update, sets status bit 14 and raises the exception. Bits 13 and 15 change only through the register port.
- R10: A task-switch pulse clears the four local enable bits (mask 0x55) of the control word, including a value written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_idx |
| exec_valid | input | 1 | A retiring instruction address is present |
| exec_addr | input | 32 | Retiring instruction address |
| data_valid | input | 1 | A data access is present |
| data_addr | input | 32 | Data access byte address |
| data_size | input | 2 | Access size code (1,2,4,8 bytes) |
| data_write | input | 1 | Access is a write |
| step_evt | input | 1 | Single-step event |
| task_sw | input | 1 | Task-switch pulse |
| dbg_exc | output | 1 | One-cycle debug-exception request |

## Verification
The table drives execute hits and misses that differ in a single address bit. It also drives data accesses that touch the last byte of a watched range, straddle its start, or sit just past its end. Length codes 1, 3 and 2 are covered, the last being the 8-byte code that also tests the downward alignment. Read and write accesses are applied to write-only, read/write and I/O slots to tell the kinds apart. Disabled slots that match, with and without a single step, separate the rebuild of the hit bits from the commit rule. Status is preset to a nonzero low nibble so that a kept value can be told apart from one rebuilt to zero.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int          REG_W      = 32;
  localparam logic [31:0] STAT_ONES  = 32'hFFFF_0FF0;
  localparam logic [31:0] CTRL_ONES  = 32'h0000_0400;
  localparam logic [31:0] LOCAL_ENS  = 32'h0000_0055;
  localparam int          KIND_BASE  = 16;
  localparam int          LEN_BASE   = 18;
  localparam int          STEP_BIT   = 14;
  localparam int          STAT_IDX   = 6;
  localparam int          STAT_ALIAS = 4;
  localparam int          CTRL_IDX   = 7;
  localparam int          CTRL_ALIAS = 5;

  typedef enum logic [1:0] {
    KIND_EXEC = 2'd0,
    KIND_WR   = 2'd1,
    KIND_IO   = 2'd2,
    KIND_RW   = 2'd3
  } slot_kind_e;

  // Non-linear slot length decode
  function automatic logic [3:0] slot_len(input logic [1:0] code);
    case (code)
      2'd0:    slot_len = 4'd1;
      2'd1:    slot_len = 4'd2;
      2'd2:    slot_len = 4'd8;
      default: slot_len = 4'd4;
    endcase
  endfunction

  // Linear access size decode
  function automatic logic [3:0] acc_len(input logic [1:0] code);
    acc_len = 4'd1 << code;
  endfunction
endpackage

// File: rtl/dbg_slot_match.sv
module dbg_slot_match
  import dbg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] slot_addr,
  input  logic [1:0]    kind,
  input  logic [1:0]    len_code,
  input  logic          exec_valid,
  input  logic [AW-1:0] exec_addr,
  input  logic          data_valid,
  input  logic [AW-1:0] data_addr,
  input  logic [1:0]    data_size,
  input  logic          data_write,
  output logic          hit
);
  logic [AW-1:0] len_mask;
  logic [AW:0]   s_lo, s_hi, a_lo, a_hi;
  logic          overlap;

  always_comb begin
    len_mask = AW'(slot_len(len_code)) - AW'(1);
    s_lo     = {1'b0, slot_addr & ~len_mask};
    s_hi     = s_lo + (AW+1)'(slot_len(len_code));
    a_lo     = {1'b0, data_addr};
    a_hi     = a_lo + (AW+1)'(acc_len(data_size));
    overlap  = (a_lo < s_hi) && (s_lo < a_hi);
    case (slot_kind_e'(kind))
      KIND_EXEC: hit = exec_valid && (exec_addr == slot_addr);
      KIND_WR:   hit = data_valid && data_write && overlap;
      KIND_RW:   hit = data_valid && overlap;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_hit_collect.sv
module dbg_hit_collect
  import dbg_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input  logic [NSLOT-1:0] hit,
  input  logic [NSLOT-1:0] slot_en,
  input  logic             step,
  input  logic [31:0]      status_q,
  output logic [31:0]      status_next,
  output logic             commit
);
  localparam logic [31:0] HIT_MASK = 32'((64'd1 << NSLOT) - 64'd1);

  always_comb begin
    commit      = (|(hit & slot_en)) || step;
    status_next = (status_q & ~HIT_MASK) | 32'(hit);
    if (step) status_next[STEP_BIT] = 1'b1;
  end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSLOT = 4,
  parameter int IDXW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [IDXW-1:0] reg_idx,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            exec_valid,
  input  logic [AW-1:0]   exec_addr,
  input  logic            data_valid,
  input  logic [AW-1:0]   data_addr,
  input  logic [1:0]      data_size,
  input  logic            data_write,
  input  logic            step_evt,
  input  logic            task_sw,
  output logic            dbg_exc
);
  logic [AW-1:0]    addr_q [NSLOT];
  logic [31:0]      stat_q, ctrl_q, ctrl_nx, stat_nx, rd_mux;
  logic [NSLOT-1:0] hit, slot_en;
  logic             commit, wr_stat, wr_ctrl;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slot_en[i] = |ctrl_q[2*i +: 2];
    dbg_slot_match #(.AW(AW)) u_match (
      .slot_addr (addr_q[i]),
      .kind      (ctrl_q[KIND_BASE + 2*i +: 2]),
      .len_code  (ctrl_q[LEN_BASE + 2*i +: 2]),
      .exec_valid(exec_valid),
      .exec_addr (exec_addr),
      .data_valid(data_valid),
      .data_addr (data_addr),
      .data_size (data_size),
      .data_write(data_write),
      .hit       (hit[i])
    );
  end

  dbg_hit_collect #(.NSLOT(NSLOT)) u_collect (
    .hit        (hit),
    .slot_en    (slot_en),
    .step       (step_evt),
    .status_q   (stat_q),
    .status_next(stat_nx),
    .commit     (commit)
  );

  assign wr_stat = reg_we && (reg_idx == IDXW'(STAT_IDX) || reg_idx == IDXW'(STAT_ALIAS));
  assign wr_ctrl = reg_we && (reg_idx == IDXW'(CTRL_IDX) || reg_idx == IDXW'(CTRL_ALIAS));

  always_comb begin
    ctrl_nx = wr_ctrl ? (reg_wdata | CTRL_ONES) : ctrl_q;
    if (task_sw) ctrl_nx = ctrl_nx & ~LOCAL_ENS;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NSLOT; i++)
      if (reg_idx == IDXW'(i)) rd_mux = 32'(addr_q[i]);
    if (reg_idx == IDXW'(STAT_IDX) || reg_idx == IDXW'(STAT_ALIAS)) rd_mux = stat_q;
    if (reg_idx == IDXW'(CTRL_IDX) || reg_idx == IDXW'(CTRL_ALIAS)) rd_mux = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) addr_q[i] <= '0;
      stat_q    <= STAT_ONES;
      ctrl_q    <= CTRL_ONES;
      dbg_exc   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++)
        if (reg_we && reg_idx == IDXW'(i)) addr_q[i] <= reg_wdata[AW-1:0];
      if (wr_stat)     stat_q <= reg_wdata | STAT_ONES;
      else if (commit) stat_q <= stat_nx;
      ctrl_q    <= ctrl_nx;
      dbg_exc   <= commit;
      reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dbg_match_chk.sv
module dbg_match_chk
  import dbg_pkg::*;
#(
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_we,
  input logic [IDXW-1:0] reg_idx,
  input logic            exec_valid,
  input logic            data_valid,
  input logic            step_evt,
  input logic            task_sw,
  input logic            dbg_exc,
  input logic [31:0]     stat_q,
  input logic [31:0]     ctrl_q
);
  logic stat_wr;
  assign stat_wr = reg_we && (reg_idx == IDXW'(STAT_IDX) || reg_idx == IDXW'(STAT_ALIAS));

  // R1
  stat_fixed_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q & STAT_ONES) == STAT_ONES);

  // R1
  ctrl_fixed_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & CTRL_ONES) == CTRL_ONES);

  // R9
  step_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (step_evt && !stat_wr) |=> (dbg_exc && stat_q[STEP_BIT]));

  // R10
  task_clear_chk: assert property (@(posedge clk) disable iff (rst)
    task_sw |=> ((ctrl_q & LOCAL_ENS) == 32'h0));

  // R8
  exc_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_exc |-> $past(step_evt || exec_valid || data_valid));

  // R7
  quiet_status_chk: assert property (@(posedge clk) disable iff (rst)
    !(step_evt || exec_valid || data_valid || reg_we) |=> $stable(stat_q));
endmodule

bind dbg_match_unit dbg_match_chk #(.IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_idx   (reg_idx),
  .exec_valid(exec_valid),
  .data_valid(data_valid),
  .step_evt  (step_evt),
  .task_sw   (task_sw),
  .dbg_exc   (dbg_exc),
  .stat_q    (stat_q),
  .ctrl_q    (ctrl_q)
);

// File: tb/tb_dbg_match_unit.sv
`timescale 1ns/1ps
module tb_dbg_match_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        exec_valid = 1'b0;
  logic [31:0] exec_addr = '0;
  logic        data_valid = 1'b0;
  logic [31:0] data_addr = '0;
  logic [1:0]  data_size = '0;
  logic        data_write = 1'b0;
  logic        step_evt = 1'b0;
  logic        task_sw = 1'b0;
  logic        dbg_exc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_match_unit dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .exec_valid(exec_valid), .exec_addr(exec_addr),
    .data_valid(data_valid), .data_addr(data_addr),
    .data_size(data_size), .data_write(data_write),
    .step_evt(step_evt), .task_sw(task_sw), .dbg_exc(dbg_exc)
  );

  // kind: 0 exec, 1 data, 2 step with exec
  typedef struct packed {
    logic [31:0] ctrl;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic        wr;
    logic        exc;
    logic [3:0]  low;
    logic        b14;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{32'h02A80001, 2'd0, 32'h1000, 2'd0, 1'b0, 1'b1, 4'h1, 1'b0}, // R4 hit
    '{32'h02A80000, 2'd0, 32'h1000, 2'd0, 1'b0, 1'b0, 4'hA, 1'b0}, // R7 disabled
    '{32'h02A80000, 2'd2, 32'h1000, 2'd0, 1'b0, 1'b1, 4'h1, 1'b1}, // R9 forced
    '{32'h02A80001, 2'd0, 32'h1001, 2'd0, 1'b0, 1'b0, 4'hA, 1'b0}, // R4 miss
    '{32'h02B60008, 2'd1, 32'h2007, 2'd0, 1'b1, 1'b1, 4'h2, 1'b0}, // R5 last byte
    '{32'h02B60008, 2'd1, 32'h2004, 2'd0, 1'b0, 1'b0, 4'hA, 1'b0}, // R6 read on wr-only
    '{32'h02B60008, 2'd1, 32'h2008, 2'd2, 1'b1, 1'b0, 4'hA, 1'b0}, // R5 past end
    '{32'h02B60008, 2'd1, 32'h2002, 2'd2, 1'b1, 1'b1, 4'h2, 1'b0}, // R5 straddle
    '{32'h02CA0040, 2'd1, 32'h4001, 2'd0, 1'b0, 1'b1, 4'h8, 1'b0}, // R3 len 8 align
    '{32'h02CA0040, 2'd1, 32'h4008, 2'd3, 1'b0, 1'b0, 4'hA, 1'b0}, // R3 len 8 end
    '{32'h027A0020, 2'd1, 32'h3001, 2'd0, 1'b0, 1'b1, 4'h4, 1'b0}, // R3 len 2
    '{32'h027A0020, 2'd1, 32'h3002, 2'd0, 1'b0, 1'b0, 4'hA, 1'b0}, // R3 len 2 end
    '{32'h02A8000C, 2'd1, 32'h2004, 2'd0, 1'b1, 1'b0, 4'hA, 1'b0}  // R6 I/O kind
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk);
    reg_idx = idx;
    @(negedge clk);
    val = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(3'd6, v); check("R1 status reset", v, 32'hFFFF0FF0);
    rd(3'd7, v); check("R1 control reset", v, 32'h00000400);
    rd(3'd0, v); check("R1 slot0 reset", v, 32'h0);
    rd(3'd3, v); check("R1 slot3 reset", v, 32'h0);

    // R2 register port
    wr(3'd0, 32'h1000); wr(3'd1, 32'h2004); wr(3'd2, 32'h3000); wr(3'd3, 32'h4006);
    rd(3'd2, v); check("R2 slot2 readback", v, 32'h3000);
    wr(3'd7, 32'h0); rd(3'd7, v); check("R2 control fixed one", v, 32'h00000400);
    wr(3'd5, 32'h00001234); rd(3'd7, v); check("R2 control alias write", v, 32'h00001634);
    wr(3'd6, 32'hFFFFFFFF); rd(3'd4, v); check("R2 status alias read", v, 32'hFFFFFFFF);
    wr(3'd4, 32'h0); rd(3'd6, v); check("R2 status fixed ones", v, 32'hFFFF0FF0);

    // Vector table: R3..R9
    for (int k = 0; k < NV; k++) begin
      wr(3'd7, VT[k].ctrl);
      wr(3'd6, 32'h0000000A);
      @(negedge clk);
      exec_valid = (VT[k].kind != 2'd1);
      exec_addr  = VT[k].addr;
      data_valid = (VT[k].kind == 2'd1);
      data_addr  = VT[k].addr;
      data_size  = VT[k].sz;
      data_write = VT[k].wr;
      step_evt   = (VT[k].kind == 2'd2);
      @(negedge clk);
      exec_valid = 1'b0; data_valid = 1'b0; step_evt = 1'b0;
      check($sformatf("R8 exc vec%0d", k), 32'(dbg_exc), 32'(VT[k].exc));
      @(negedge clk);
      check($sformatf("R8 pulse end vec%0d", k), 32'(dbg_exc), 32'h0);
      rd(3'd6, v);
      check($sformatf("R7 status vec%0d", k), v,
            32'hFFFF0FF0 | (32'(VT[k].b14) << 14) | 32'(VT[k].low));
    end

    // R9 step with no match rebuilds low bits to zero
    wr(3'd7, 32'h02A80000);
    wr(3'd6, 32'h0000A00F);
    @(negedge clk); step_evt = 1'b1;
    @(negedge clk); step_evt = 1'b0;
    check("R9 step exc", 32'(dbg_exc), 32'h1);
    rd(3'd6, v); check("R9 step status keeps 13,15", v, 32'hFFFFEFF0);

    // R7 write wins over a same-cycle commit
    wr(3'd7, 32'h02A80001);
    @(negedge clk);
    exec_valid = 1'b1; exec_addr = 32'h1000;
    reg_we = 1'b1; reg_idx = 3'd6; reg_wdata = 32'h00000005;
    @(negedge clk);
    exec_valid = 1'b0; reg_we = 1'b0;
    rd(3'd6, v); check("R2 write beats update", v, 32'hFFFF0FF5);

    // R10 task switch
    wr(3'd7, 32'h000000FF);
    @(negedge clk); task_sw = 1'b1;
    @(negedge clk); task_sw = 1'b0;
    rd(3'd7, v); check("R10 local enables cleared", v, 32'h000004AA);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 3'd7; reg_wdata = 32'h000000FF; task_sw = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; task_sw = 1'b0;
    rd(3'd7, v); check("R10 clear with same-cycle write", v, 32'h000004AA);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule